// File: doc/BRIEF.md
# Quadrature and Single-Input Pulse Counter

This block counts pulses on two input lines, S0 and S1, that are already synchronous to the system clock. In single-input mode it counts one chosen edge of S0, and the direction comes either from a configuration bit or from the level of S1. In quadrature mode it decodes the two lines as a Gray-coded phase pair at 1X, 2X or 4X resolution and gets the direction from the phase relation of the two lines.

A main up/down counter wraps between zero and a programmable top value. A second top register holds the next top value, which takes effect at the next wrap. An auxiliary counter only counts upward and tallies a chosen class of events. Commands start, stop and clear each counter, and one command loads the top value into the main count. The outputs give the counts, the running state of each counter, one-cycle overflow, underflow, auxiliary-overflow and direction-change pulses, and a direction flag. All outputs are registered. An input change that is sampled at clock edge k shows on the outputs right after edge k. The block has no data stream, so none of its pins use a valid/ready handshake. Every pin is a plain level or a one-cycle strobe.

Top module: `pulse_quad_counter`

## Requirements
- R1: After reset both counts are 0, `top_o` equals parameter TOP_RST (default all ones), both counters are stopped, `topb_valid_o`, `dir_down_o` and all pulse outputs are 0.
- R2: With `mode_i`=0 (single input) and `dir_from_s1_i`=0, each rising S0 edge (`edge_neg_i`=0) or each falling S0 edge (`edge_neg_i`=1) is one event. The event is up when `dir_down_i`=0 and down when `dir_down_i`=1.
- R3: With `mode_i`=0 and `dir_from_s1_i`=1, an event is down when (`s1_i` XOR `edge_neg_i`)=1 and up otherwise.
- R4: Quadrature resolution: `mode_i`=1 (1X) counts only on rising S0 edges, `mode_i`=2 (2X) counts on both S0 edges, and `mode_i`=3 (4X) counts on every edge of S0 or S1.
- R5: Quadrature direction: in state order {S0,S1} 00→10→11→01→00 each step is an up event and the reverse order gives down events. A sample in which S0 and S1 both changed is no event.
- R6: Main qualifier `main_qual_i`: 0 counts up on up events and down on down events, 1 counts only up events, 2 counts only down events, 3 behaves as 0.
- R7: An up count with the count equal to `top_o` makes the count 0 and raises `ovf_o` for exactly one cycle.
- R8: A down count at count 0 loads the count with the top value in effect after that edge and raises `unf_o` for one cycle.
- R9: A `topb_wr_i` strobe stores `topb_wdata_i` and sets `topb_valid_o`. At the next overflow or underflow `top_o` takes the buffered value and `topb_valid_o` clears.
- R10: The auxiliary counter only increments. `aux_qual_i` 0 (or 3) counts all events, 1 counts up events only, 2 counts down events only.
- R11: The auxiliary counter wraps from all ones to 0 and raises `aux_ovf_o` for one cycle.
- R12: Start and stop strobes set and clear each running flag, and stop wins when both arrive together. A stopped counter ignores events. `clr_main_i`/`clr_aux_i` zero a count. `load_now_i` copies `top_o` into the main count, and `clr_main_i` wins over `load_now_i`.
- R13: `dir_down_o` follows the last decoded event (0 up, 1 down), and `dir_chg_o` pulses for one cycle when an event flips it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s0_i | input | 1 | Count input S0, synchronous |
| s1_i | input | 1 | Count input S1, synchronous |
| mode_i | input | 2 | 0 single, 1 quad 1X, 2 quad 2X, 3 quad 4X |
| edge_neg_i | input | 1 | Single mode: count falling S0 edges and invert S1 |
| dir_from_s1_i | input | 1 | Single mode: direction taken from S1 |
| dir_down_i | input | 1 | Single mode fixed direction, 1 = down |
| main_qual_i | input | 2 | Main counter event qualifier |
| aux_qual_i | input | 2 | Auxiliary counter event qualifier |
| start_main_i | input | 1 | Start main counter strobe |
| stop_main_i | input | 1 | Stop main counter strobe |
| start_aux_i | input | 1 | Start auxiliary counter strobe |
| stop_aux_i | input | 1 | Stop auxiliary counter strobe |
| clr_main_i | input | 1 | Clear main count strobe |
| clr_aux_i | input | 1 | Clear auxiliary count strobe |
| load_now_i | input | 1 | Copy top value into main count |
| top_wr_i | input | 1 | Write top value directly |
| top_wdata_i | input | W | Direct top value |
| topb_wr_i | input | 1 | Write top buffer |
| topb_wdata_i | input | W | Buffered top value |
| count_o | output | W | Main count |
| aux_count_o | output | W | Auxiliary count |
| top_o | output | W | Top value in effect |
| topb_valid_o | output | 1 | Top buffer holds a pending value |
| main_running_o | output | 1 | Main counter running |
| aux_running_o | output | 1 | Auxiliary counter running |
| dir_down_o | output | 1 | Direction of last event, 1 = down |
| ovf_o | output | 1 | Main overflow pulse |
| unf_o | output | 1 | Main underflow pulse |
| aux_ovf_o | output | 1 | Auxiliary overflow pulse |
| dir_chg_o | output | 1 | Direction change pulse |

## Verification
The assertions assume that S0 and S1 are already synchronous to `clk` and that the strobes change only between clock edges. The bench therefore drives every input on the falling clock edge and holds it across the next rising edge. The properties also assume that a counter that is stopped and receives no clear or load holds its value. The stimulus checks this by sending events while stopped. Before any mode switch the bench returns both inputs to a quiet state, so a switch does not create an edge that belongs to neither mode.

// File: rtl/pqc_pkg.sv
package pqc_pkg;
  typedef enum logic [1:0] {
    PQC_SINGLE = 2'd0,
    PQC_QUAD1X = 2'd1,
    PQC_QUAD2X = 2'd2,
    PQC_QUAD4X = 2'd3
  } pqc_mode_e;

  typedef enum logic [1:0] {
    PQC_Q_BOTH = 2'd0,
    PQC_Q_UP   = 2'd1,
    PQC_Q_DOWN = 2'd2,
    PQC_Q_ALT  = 2'd3
  } pqc_qual_e;
endpackage

// File: rtl/pqc_edge_decode.sv
module pqc_edge_decode
  import pqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s0_i,
  input  logic       s1_i,
  input  logic [1:0] mode_i,
  input  logic       edge_neg_i,
  input  logic       dir_from_s1_i,
  input  logic       dir_down_i,
  output logic       up_ev_o,
  output logic       dn_ev_o
);
  logic s0_q, s1_q, primed_q;
  logic rise0, fall0, chg0, chg1, hit, down;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q     <= 1'b0;
      s1_q     <= 1'b0;
      primed_q <= 1'b0;
    end else begin
      s0_q     <= s0_i;
      s1_q     <= s1_i;
      primed_q <= 1'b1;
    end
  end

  assign rise0 = s0_i & ~s0_q;
  assign fall0 = ~s0_i & s0_q;
  assign chg0  = rise0 | fall0;
  assign chg1  = s1_i ^ s1_q;

  // Phase rule: S0 leading S1 is the up direction.
  always_comb begin
    hit  = 1'b0;
    down = 1'b0;
    unique case (pqc_mode_e'(mode_i))
      PQC_SINGLE: begin
        hit  = edge_neg_i ? fall0 : rise0;
        down = dir_from_s1_i ? (s1_i ^ edge_neg_i) : dir_down_i;
      end
      PQC_QUAD1X: begin
        hit  = rise0 & ~chg1;
        down = s1_i;
      end
      PQC_QUAD2X: begin
        hit  = chg0 & ~chg1;
        down = ~(s0_i ^ s1_i);
      end
      PQC_QUAD4X: begin
        hit  = chg0 ^ chg1;
        down = chg0 ? ~(s0_i ^ s1_i) : (s0_i ^ s1_i);
      end
      default: begin
        hit  = 1'b0;
        down = 1'b0;
      end
    endcase
  end

  assign up_ev_o = primed_q & hit & ~down;
  assign dn_ev_o = primed_q & hit & down;
endmodule

// File: rtl/pqc_main_counter.sv
module pqc_main_counter
  import pqc_pkg::*;
#(
  parameter int unsigned   W       = 16,
  parameter logic [W-1:0]  TOP_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_ev_i,
  input  logic         dn_ev_i,
  input  logic [1:0]   qual_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         clr_i,
  input  logic         load_now_i,
  input  logic         top_wr_i,
  input  logic [W-1:0] top_wdata_i,
  input  logic         topb_wr_i,
  input  logic [W-1:0] topb_wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] top_o,
  output logic         topb_valid_o,
  output logic         running_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] count_q, top_q, topb_q, count_d, top_d;
  logic         valid_q, run_q, ovf_q, unf_q;
  logic         do_inc, do_dec, wrap_up, wrap_dn, reload, quiet;

  assign do_inc  = run_q & up_ev_i & (pqc_qual_e'(qual_i) != PQC_Q_DOWN);
  assign do_dec  = run_q & dn_ev_i & (pqc_qual_e'(qual_i) != PQC_Q_UP);
  assign wrap_up = do_inc & (count_q == top_q);
  assign wrap_dn = do_dec & (count_q == ZERO);
  assign reload  = (wrap_up | wrap_dn) & valid_q;
  assign quiet   = ~clr_i & ~load_now_i;

  always_comb begin
    top_d = reload ? topb_q : top_q;
    if (top_wr_i) top_d = top_wdata_i;
  end

  always_comb begin
    count_d = count_q;
    if (clr_i)           count_d = ZERO;
    else if (load_now_i) count_d = top_q;
    else if (do_inc)     count_d = wrap_up ? ZERO : count_q + 1'b1;
    else if (do_dec)     count_d = wrap_dn ? top_d : count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= ZERO;
      top_q   <= TOP_RST;
      topb_q  <= ZERO;
      valid_q <= 1'b0;
      run_q   <= 1'b0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      top_q   <= top_d;
      ovf_q   <= wrap_up & quiet;
      unf_q   <= wrap_dn & quiet;
      if (stop_i)       run_q <= 1'b0;
      else if (start_i) run_q <= 1'b1;
      if (topb_wr_i) begin
        topb_q  <= topb_wdata_i;
        valid_q <= 1'b1;
      end else if (reload) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign count_o      = count_q;
  assign top_o        = top_q;
  assign topb_valid_o = valid_q;
  assign running_o    = run_q;
  assign ovf_o        = ovf_q;
  assign unf_o        = unf_q;
endmodule

// File: rtl/pqc_aux_counter.sv
module pqc_aux_counter
  import pqc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_ev_i,
  input  logic         dn_ev_i,
  input  logic [1:0]   qual_i,
  input  logic         start_i,
  input  logic         stop_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o,
  output logic         running_o,
  output logic         ovf_o
);
  logic [W-1:0] count_q;
  logic         run_q, ovf_q, sel, do_inc;

  always_comb begin
    unique case (pqc_qual_e'(qual_i))
      PQC_Q_UP:   sel = up_ev_i;
      PQC_Q_DOWN: sel = dn_ev_i;
      default:    sel = up_ev_i | dn_ev_i;
    endcase
  end

  assign do_inc = run_q & sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      ovf_q <= do_inc & (&count_q) & ~clr_i;
      if (clr_i)       count_q <= '0;
      else if (do_inc) count_q <= count_q + 1'b1;
      if (stop_i)       run_q <= 1'b0;
      else if (start_i) run_q <= 1'b1;
    end
  end

  assign count_o   = count_q;
  assign running_o = run_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/pulse_quad_counter.sv
module pulse_quad_counter
  import pqc_pkg::*;
#(
  parameter int unsigned  W       = 16,
  parameter logic [W-1:0] TOP_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s0_i,
  input  logic         s1_i,
  input  logic [1:0]   mode_i,
  input  logic         edge_neg_i,
  input  logic         dir_from_s1_i,
  input  logic         dir_down_i,
  input  logic [1:0]   main_qual_i,
  input  logic [1:0]   aux_qual_i,
  input  logic         start_main_i,
  input  logic         stop_main_i,
  input  logic         start_aux_i,
  input  logic         stop_aux_i,
  input  logic         clr_main_i,
  input  logic         clr_aux_i,
  input  logic         load_now_i,
  input  logic         top_wr_i,
  input  logic [W-1:0] top_wdata_i,
  input  logic         topb_wr_i,
  input  logic [W-1:0] topb_wdata_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] aux_count_o,
  output logic [W-1:0] top_o,
  output logic         topb_valid_o,
  output logic         main_running_o,
  output logic         aux_running_o,
  output logic         dir_down_o,
  output logic         ovf_o,
  output logic         unf_o,
  output logic         aux_ovf_o,
  output logic         dir_chg_o
);
  logic up_ev, dn_ev, dir_q, chg_q;

  pqc_edge_decode u_dec (
    .clk(clk), .rst_n(rst_n), .s0_i(s0_i), .s1_i(s1_i), .mode_i(mode_i),
    .edge_neg_i(edge_neg_i), .dir_from_s1_i(dir_from_s1_i),
    .dir_down_i(dir_down_i), .up_ev_o(up_ev), .dn_ev_o(dn_ev)
  );

  pqc_main_counter #(.W(W), .TOP_RST(TOP_RST)) u_main (
    .clk(clk), .rst_n(rst_n), .up_ev_i(up_ev), .dn_ev_i(dn_ev),
    .qual_i(main_qual_i), .start_i(start_main_i), .stop_i(stop_main_i),
    .clr_i(clr_main_i), .load_now_i(load_now_i), .top_wr_i(top_wr_i),
    .top_wdata_i(top_wdata_i), .topb_wr_i(topb_wr_i),
    .topb_wdata_i(topb_wdata_i), .count_o(count_o), .top_o(top_o),
    .topb_valid_o(topb_valid_o), .running_o(main_running_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  pqc_aux_counter #(.W(W)) u_aux (
    .clk(clk), .rst_n(rst_n), .up_ev_i(up_ev), .dn_ev_i(dn_ev),
    .qual_i(aux_qual_i), .start_i(start_aux_i), .stop_i(stop_aux_i),
    .clr_i(clr_aux_i), .count_o(aux_count_o), .running_o(aux_running_o),
    .ovf_o(aux_ovf_o)
  );

  // Direction tracks every decoded event, independent of qualifiers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      chg_q <= 1'b0;
    end else begin
      chg_q <= (up_ev | dn_ev) & (dn_ev != dir_q);
      if (up_ev | dn_ev) dir_q <= dn_ev;
    end
  end

  assign dir_down_o = dir_q;
  assign dir_chg_o  = chg_q;
endmodule

// File: rtl/pqc_checker.sv
module pqc_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr_main_i,
  input logic         load_now_i,
  input logic         clr_aux_i,
  input logic [W-1:0] count_o,
  input logic [W-1:0] aux_count_o,
  input logic [W-1:0] top_o,
  input logic         topb_valid_o,
  input logic         main_running_o,
  input logic         aux_running_o,
  input logic         dir_down_o,
  input logic         ovf_o,
  input logic         unf_o,
  input logic         aux_ovf_o,
  input logic         dir_chg_o
);
  p_ovf_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> count_o == '0);

  p_unf_loads_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |-> count_o == top_o);

  p_wrap_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_o && unf_o));

  p_topb_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(topb_valid_o) |-> (ovf_o || unf_o));

  p_aux_wrap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    aux_ovf_o |-> aux_count_o == '0);

  p_main_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_running_o && !clr_main_i && !load_now_i) |=> $stable(count_o));

  p_aux_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!aux_running_o && !clr_aux_i) |=> $stable(aux_count_o));

  p_dir_flip_r13: assert property (@(posedge clk) disable iff (!rst_n)
    dir_chg_o |-> dir_down_o != $past(dir_down_o));
endmodule

bind pulse_quad_counter pqc_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_main_i(clr_main_i), .load_now_i(load_now_i),
  .clr_aux_i(clr_aux_i), .count_o(count_o), .aux_count_o(aux_count_o),
  .top_o(top_o), .topb_valid_o(topb_valid_o), .main_running_o(main_running_o),
  .aux_running_o(aux_running_o), .dir_down_o(dir_down_o), .ovf_o(ovf_o),
  .unf_o(unf_o), .aux_ovf_o(aux_ovf_o), .dir_chg_o(dir_chg_o)
);

// File: tb/pulse_quad_counter_tb.sv
module pulse_quad_counter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s0 = 0, s1 = 0, edge_neg = 0, dir_from_s1 = 0, dir_down = 0;
  logic [1:0] mode = 2'd3, main_qual = 0, aux_qual = 0;
  logic start_main = 0, stop_main = 0, start_aux = 0, stop_aux = 0;
  logic clr_main = 0, clr_aux = 0, load_now = 0, top_wr = 0, topb_wr = 0;
  logic [W-1:0] top_wdata = 0, topb_wdata = 0;
  logic [W-1:0] count, aux_count, top;
  logic topb_valid, main_running, aux_running, dir_dn, ovf, unf, aux_ovf, dir_chg;
  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct packed { logic s0; logic s1; logic [15:0] cnt; logic dir; } vec_t;
  // 4X walk from count 0: forward, reverse, forward, an illegal double change.
  localparam vec_t VECS [11] = '{
    '{1'b1, 1'b0, 16'd1, 1'b0}, '{1'b1, 1'b1, 16'd2, 1'b0},
    '{1'b0, 1'b1, 16'd3, 1'b0}, '{1'b0, 1'b0, 16'd4, 1'b0},
    '{1'b0, 1'b1, 16'd3, 1'b1}, '{1'b1, 1'b1, 16'd2, 1'b1},
    '{1'b1, 1'b0, 16'd1, 1'b1}, '{1'b0, 1'b0, 16'd0, 1'b1},
    '{1'b1, 1'b0, 16'd1, 1'b0}, '{1'b0, 1'b1, 16'd1, 1'b0},
    '{1'b0, 1'b0, 16'd2, 1'b0}
  };

  pulse_quad_counter u_dut (
    .clk(clk), .rst_n(rst_n), .s0_i(s0), .s1_i(s1), .mode_i(mode),
    .edge_neg_i(edge_neg), .dir_from_s1_i(dir_from_s1), .dir_down_i(dir_down),
    .main_qual_i(main_qual), .aux_qual_i(aux_qual),
    .start_main_i(start_main), .stop_main_i(stop_main),
    .start_aux_i(start_aux), .stop_aux_i(stop_aux),
    .clr_main_i(clr_main), .clr_aux_i(clr_aux), .load_now_i(load_now),
    .top_wr_i(top_wr), .top_wdata_i(top_wdata),
    .topb_wr_i(topb_wr), .topb_wdata_i(topb_wdata),
    .count_o(count), .aux_count_o(aux_count), .top_o(top),
    .topb_valid_o(topb_valid), .main_running_o(main_running),
    .aux_running_o(aux_running), .dir_down_o(dir_dn), .ovf_o(ovf),
    .unf_o(unf), .aux_ovf_o(aux_ovf), .dir_chg_o(dir_chg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive on a falling edge, then wait past one rising edge.
  task automatic step(input logic a, input logic b);
    @(negedge clk); s0 = a; s1 = b;
    @(negedge clk);
  endtask

  task automatic pulse_s0();
    step(1'b1, s1);
    step(1'b0, s1);
  endtask

  task automatic clear_main();
    @(negedge clk); clr_main = 1;
    @(negedge clk); clr_main = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prev_dir;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 aux", aux_count, 0);
    chk("R1 top", top, 16'hFFFF);
    chk("R1 flags", {topb_valid, main_running, aux_running, dir_dn, ovf, unf, aux_ovf, dir_chg}, 0);

    @(negedge clk); start_main = 1; start_aux = 1;
    @(negedge clk); start_main = 0; start_aux = 0;
    chk("R12 started", {main_running, aux_running}, 3);

    // R5 / R4 / R13 table walk in 4X mode
    prev_dir = 1'b0;
    for (int i = 0; i < 11; i++) begin
      step(VECS[i].s0, VECS[i].s1);
      chk("R5 count", count, VECS[i].cnt);
      chk("R13 dir", dir_dn, VECS[i].dir);
      chk("R13 dir_chg", dir_chg, VECS[i].dir != prev_dir);
      prev_dir = VECS[i].dir;
    end
    chk("R10 aux all events", aux_count, 10);

    // R4 2X and 1X resolution
    mode = 2'd2; clear_main();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    chk("R4 2X count", count, 2);
    mode = 2'd1; clear_main();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
    chk("R4 1X count", count, 1);
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
    chk("R4 1X reverse", count, 0);

    // R2 / R3 single input
    mode = 2'd0; clear_main();
    repeat (3) pulse_s0();
    chk("R2 rising up", count, 3);
    edge_neg = 1;
    repeat (2) pulse_s0();
    chk("R2 falling up", count, 5);
    edge_neg = 0; dir_down = 1;
    pulse_s0();
    chk("R2 fixed down", count, 4);
    dir_down = 0; dir_from_s1 = 1;
    step(0, 1);
    pulse_s0();
    chk("R3 s1 high down", count, 3);
    edge_neg = 1;
    pulse_s0();
    chk("R3 inverted up", count, 4);
    edge_neg = 0; dir_from_s1 = 0;
    step(0, 0);

    // R6 / R10 qualifiers
    mode = 2'd3; clear_main();
    @(negedge clk); clr_aux = 1; @(negedge clk); clr_aux = 0;
    main_qual = 2'd1; aux_qual = 2'd2;
    step(1, 0);
    chk("R6 up-only counts up", count, 1);
    chk("R10 down-only skips up", aux_count, 0);
    step(0, 0);
    chk("R6 up-only ignores down", count, 1);
    chk("R10 down-only counts down", aux_count, 1);
    main_qual = 2'd2; aux_qual = 2'd1;
    step(0, 1);
    chk("R6 down-only counts down", count, 0);
    step(0, 0);
    chk("R6 down-only ignores up", count, 0);
    chk("R10 up-only aux", aux_count, 2);
    main_qual = 0; aux_qual = 0;

    // R7 overflow
    @(negedge clk); top_wr = 1; top_wdata = 16'd3;
    @(negedge clk); top_wr = 0;
    clear_main();
    step(1, 0); step(1, 1); step(0, 1);
    chk("R7 at top", count, 3);
    step(0, 0);
    chk("R7 wrap", count, 0);
    chk("R7 ovf pulse", ovf, 1);
    @(negedge clk);
    chk("R7 ovf one cycle", ovf, 0);

    // R8 underflow
    step(0, 1);
    chk("R8 load top", count, 3);
    chk("R8 unf pulse", unf, 1);

    // R9 buffered top
    @(negedge clk); topb_wr = 1; topb_wdata = 16'd5;
    @(negedge clk); topb_wr = 0;
    chk("R9 valid set", topb_valid, 1);
    chk("R9 top unchanged", top, 3);
    step(0, 0);
    chk("R9 wrap count", count, 0);
    chk("R9 top reloaded", top, 5);
    chk("R9 valid cleared", topb_valid, 0);

    // R12 commands
    @(negedge clk); stop_main = 1; @(negedge clk); stop_main = 0;
    step(1, 0);
    chk("R12 stopped ignores", count, 0);
    @(negedge clk); start_main = 1; stop_main = 1;
    @(negedge clk); start_main = 0; stop_main = 0;
    chk("R12 stop wins", main_running, 0);
    @(negedge clk); start_main = 1; @(negedge clk); start_main = 0;
    step(1, 1);
    chk("R12 restarted", count, 1);
    @(negedge clk); load_now = 1; @(negedge clk); load_now = 0;
    chk("R12 load now", count, 5);
    @(negedge clk); load_now = 1; clr_main = 1;
    @(negedge clk); load_now = 0; clr_main = 0;
    chk("R12 clear beats load", count, 0);

    // R11 auxiliary wrap
    @(negedge clk); stop_main = 1; clr_aux = 1;
    @(negedge clk); stop_main = 0; clr_aux = 0;
    for (int i = 0; i < 65535; i++) begin
      @(negedge clk);
      case ({s0, s1})
        2'b00: begin s0 = 1; s1 = 0; end
        2'b10: begin s0 = 1; s1 = 1; end
        2'b11: begin s0 = 0; s1 = 1; end
        default: begin s0 = 0; s1 = 0; end
      endcase
    end
    @(negedge clk);
    chk("R11 aux at max", aux_count, 16'hFFFF);
    chk("R11 no early ovf", aux_ovf, 0);
    case ({s0, s1})
      2'b00: begin s0 = 1; s1 = 0; end
      2'b10: begin s0 = 1; s1 = 1; end
      2'b11: begin s0 = 0; s1 = 1; end
      default: begin s0 = 0; s1 = 0; end
    endcase
    @(negedge clk);
    chk("R11 aux wrapped", aux_count, 0);
    chk("R11 aux ovf pulse", aux_ovf, 1);
    @(negedge clk);
    chk("R11 aux ovf one cycle", aux_ovf, 0);
    chk("R12 stopped main held", count, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule